// File: doc/BRIEF.md
# Dual-Mode Integer Haar Lifting Unit

This block performs one level of the integer-to-integer Haar wavelet transform using lifting steps. It runs in either direction on the same arithmetic. In forward mode it turns a pair of samples (even, then odd) into an approximation and a detail coefficient. In inverse mode it turns an (approximation, detail) pair back into the original even and odd samples, bit for bit.

Input arrives one beat at a time on a valid/ready stream. Two consecutive accepted beats form a pair. A last-beat marker ends a stream. If the stream ends on the first beat of a pair, that beat is kept and flagged rather than transformed. The stream may be of any length. Each result pair leaves together on two output buses, with a single-cycle valid pulse and a fixed latency.

The datapath has no multiplier. Halving is an arithmetic right shift. One subtractor and one adder do all the work. Multiplexers on their inputs, steered by the pair's mode, switch between the forward and the inverse computation.

Top module: `haar_lift_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `orphan_flag` and `in_ready` are 0 after that edge. After the first edge with `rst_n` high, `in_ready` is 1.
- R2: A beat is accepted at a rising edge where `in_valid` and `in_ready` are both 1. Accepted beats alternate between the first and second slot of a pair, starting with the first slot after reset.
- R3: Forward mode (`mode_inv`=0) takes the first beat as even `e` and the second as odd `o`. It outputs `out_second` = d = o − e and `out_first` = s = e + floor(d/2), both as SAMPLE_W+1-bit two's complement values.
- R4: Inverse mode (`mode_inv`=1) takes the first beat as s and the second as d, using all SAMPLE_W+1 bits of `in_data`. It outputs `out_first` = e = s − floor(d/2) and `out_second` = o = d + e, each taken modulo 2^(SAMPLE_W+1).
- R5: Feeding the forward outputs (s, d) back in inverse mode returns the original even and odd samples exactly, sign-extended to SAMPLE_W+1 bits.
- R6: `out_valid` is 1 in the cycle after the second rising edge that follows the edge accepting the second beat of a pair.
- R7: `out_valid` is never 1 in two consecutive cycles. With no gaps in the input, pairs come out one every two cycles.
- R8: A first-slot beat accepted with `in_last`=1 forms no pair and produces no `out_valid`. After that edge, `orphan_flag` is 1 and `orphan_data` holds the beat's `in_data`. Both stay held until the next accepted beat clears the flag. The next accepted beat starts a new pair.
- R9: The mode of a pair is the value of `mode_inv` when its first beat is accepted. `mode_inv` at the second beat has no effect.
- R10: In forward mode only the low SAMPLE_W bits of `in_data` are used, as a signed sample. Bit SAMPLE_W is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_inv | input | 1 | 0 = forward transform, 1 = inverse transform; sampled with the first beat of a pair |
| in_valid | input | 1 | Input beat present |
| in_last | input | 1 | Marks the final beat of a stream |
| in_data | input | SAMPLE_W+1 | Sample or coefficient, two's complement |
| in_ready | output | 1 | Beat can be accepted |
| out_valid | output | 1 | One-cycle pulse: result pair on the output buses |
| out_first | output | SAMPLE_W+1 | Approximation (forward) or even sample (inverse) |
| out_second | output | SAMPLE_W+1 | Detail (forward) or odd sample (inverse) |
| orphan_flag | output | 1 | An unpaired final beat is held |
| orphan_data | output | SAMPLE_W+1 | The held unpaired beat |

## Verification
The assertions check the following on every cycle:
- the two-stage latency from a captured pair to `out_valid`;
- the single-cycle width of each output pulse;
- that an orphaned beat never produces a pair;
- that a forward detail never reaches the one value a SAMPLE_W-bit difference cannot produce;
- that every forward result, undone, gives back an even sample within SAMPLE_W bits.

Only the bench scenarios show the arithmetic itself. At a 4-bit sample width they cover every forward pair, every inverse pair and the lossless round trip. They also cover the mode latching at the first beat, the ignored top bit in forward mode, the back-to-back throughput, and the orphan hold and release.

// File: rtl/haar_pkg.sv
// Shared types for the Haar lifting unit.
// Assumes: nothing beyond a single-bit direction code.
package haar_pkg;

    // Transform direction carried with each pair through the pipeline.
    typedef enum logic {
        LIFT_FWD = 1'b0,
        LIFT_INV = 1'b1
    } lift_mode_e;

endpackage

// File: rtl/haar_pair_capture.sv
// Pair capture: accepts single beats and groups two of them into one pair.
// It latches the mode with the first beat and sign-conditions forward samples.
// A stream that ends on a first-slot beat leaves that beat held as an orphan.
// Assumes: synchronous active-low reset; no back-pressure from downstream.
module haar_pair_capture
    import haar_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_inv,
    input  logic                  in_valid,
    input  logic                  in_last,
    input  logic [SAMPLE_W:0]     in_data,
    output logic                  in_ready,
    output logic                  pair_valid,
    output logic [SAMPLE_W:0]     pair_a,
    output logic [SAMPLE_W:0]     pair_b,
    output lift_mode_e            pair_mode,
    output logic                  orphan_flag,
    output logic [SAMPLE_W:0]     orphan_data
);
    localparam int DW = SAMPLE_W + 1;

    logic             have_first;
    logic [DW-1:0]    held_a;
    lift_mode_e       held_mode;
    logic             accept;
    lift_mode_e       beat_mode;
    logic [DW-1:0]    beat_cond;

    assign accept = in_valid && in_ready;

    // Mode of the current beat: the first slot uses the live input, the second uses the latched one.
    always_comb begin
        beat_mode = have_first ? held_mode : lift_mode_e'(mode_inv);
    end

    // Forward samples use only the low SAMPLE_W bits, sign-extended.
    always_comb begin
        if (beat_mode == LIFT_FWD)
            beat_cond = {in_data[SAMPLE_W-1], in_data[SAMPLE_W-1:0]};
        else
            beat_cond = in_data;
    end

    // Ready comes up one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Slot tracking, first-beat hold and pair hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_first <= 1'b0;
            held_a     <= '0;
            held_mode  <= LIFT_FWD;
            pair_valid <= 1'b0;
            pair_a     <= '0;
            pair_b     <= '0;
            pair_mode  <= LIFT_FWD;
        end else begin
            pair_valid <= 1'b0;
            if (accept) begin
                if (!have_first) begin
                    if (!in_last) begin
                        have_first <= 1'b1;
                        held_a     <= beat_cond;
                        held_mode  <= beat_mode;
                    end
                end else begin
                    have_first <= 1'b0;
                    pair_valid <= 1'b1;
                    pair_a     <= held_a;
                    pair_b     <= beat_cond;
                    pair_mode  <= held_mode;
                end
            end
        end
    end

    // Orphan hold: set by a stream ending on a first slot, cleared by the next accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            orphan_flag <= 1'b0;
            orphan_data <= '0;
        end else if (accept) begin
            orphan_flag <= in_last && !have_first;
            if (in_last && !have_first)
                orphan_data <= in_data;
        end
    end

    // R8: an orphaned beat never yields a pair on the following cycle.
    p_orphan_no_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last && !have_first) |=> (!pair_valid && orphan_flag));

    // R2: pairs are never produced on consecutive cycles.
    p_pair_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

endmodule

// File: rtl/haar_sub_stage.sv
// Shared subtractor stage. Forward: detail = odd - even.
// Inverse: even = s - (d >>> 1). The operand multiplexers switch with the pair's mode.
// It registers the difference together with the operand that the adder needs next.
// Assumes: operands are already SAMPLE_W+1-bit two's complement.
module haar_sub_stage
    import haar_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pair_valid,
    input  logic [SAMPLE_W:0]     pair_a,
    input  logic [SAMPLE_W:0]     pair_b,
    input  lift_mode_e            pair_mode,
    output logic                  s2_valid,
    output logic [SAMPLE_W:0]     s2_diff,
    output logic [SAMPLE_W:0]     s2_pass,
    output lift_mode_e            s2_mode
);
    localparam int DW = SAMPLE_W + 1;
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {SAMPLE_W{1'b0}}};

    logic [DW-1:0] minuend;
    logic [DW-1:0] subtrahend;
    logic [DW-1:0] diff;
    logic [DW-1:0] half_b;

    assign half_b = {pair_b[DW-1], pair_b[DW-1:1]};

    // Steer the subtractor inputs by mode.
    always_comb begin
        if (pair_mode == LIFT_FWD) begin
            minuend    = pair_b;
            subtrahend = pair_a;
        end else begin
            minuend    = pair_a;
            subtrahend = half_b;
        end
    end

    // The single subtractor of the datapath.
    assign diff = minuend - subtrahend;

    // Register the difference, the operand passed on to the adder, and the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_diff  <= '0;
            s2_pass  <= '0;
            s2_mode  <= LIFT_FWD;
        end else begin
            s2_valid <= pair_valid;
            s2_mode  <= pair_mode;
            s2_diff  <= diff;
            s2_pass  <= (pair_mode == LIFT_FWD) ? pair_a : pair_b;
        end
    end

    // R3: a difference of two SAMPLE_W-bit samples never reaches the most negative detail code.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_mode == LIFT_FWD) |-> (s2_diff != MOST_NEG));

    // R6: a captured pair always moves on to the adder stage.
    p_stage_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> s2_valid);

endmodule

// File: rtl/haar_add_stage.sv
// Shared adder stage. Forward: s = even + (d >>> 1).
// Inverse: odd = d + even. It then routes the sum and the difference to the output pair.
// Assumes: inputs come from haar_sub_stage one cycle earlier.
module haar_add_stage
    import haar_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s2_valid,
    input  logic [SAMPLE_W:0]     s2_diff,
    input  logic [SAMPLE_W:0]     s2_pass,
    input  lift_mode_e            s2_mode,
    output logic                  out_valid,
    output logic [SAMPLE_W:0]     out_first,
    output logic [SAMPLE_W:0]     out_second,
    output lift_mode_e            out_mode
);
    localparam int DW = SAMPLE_W + 1;

    logic [DW-1:0] addend;
    logic [DW-1:0] sum;
    logic [DW-1:0] even_chk;

    // Steer the adder's second input: the halved detail (forward) or the new even sample (inverse).
    always_comb begin
        if (s2_mode == LIFT_FWD)
            addend = {s2_diff[DW-1], s2_diff[DW-1:1]};
        else
            addend = s2_diff;
    end

    // The single adder of the datapath.
    assign sum = s2_pass + addend;

    // Register the result pair in output order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_first  <= '0;
            out_second <= '0;
            out_mode   <= LIFT_FWD;
        end else begin
            out_valid <= s2_valid;
            out_mode  <= s2_mode;
            if (s2_mode == LIFT_FWD) begin
                out_first  <= sum;
                out_second <= s2_diff;
            end else begin
                out_first  <= s2_diff;
                out_second <= sum;
            end
        end
    end

    // Undoing a forward result gives back a sample that fits in SAMPLE_W bits.
    assign even_chk = out_first - {out_second[DW-1], out_second[DW-1:1]};

    // R5: every forward output is invertible to an in-range even sample.
    p_fwd_invertible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == LIFT_FWD) |-> (even_chk[DW-1] == even_chk[DW-2]));

    // R7: the output valid pulse lasts one cycle.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6: the output pulse follows the adder stage by exactly one cycle.
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> out_valid);

endmodule

// File: rtl/haar_lift_unit.sv
// Top level of the dual-mode integer Haar lifting unit.
// Pipeline: pair capture -> shared subtractor -> shared adder -> output registers.
// Assumes: synchronous active-low reset; the consumer always takes the output pulse.
module haar_lift_unit
    import haar_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_inv,
    input  logic                  in_valid,
    input  logic                  in_last,
    input  logic [SAMPLE_W:0]     in_data,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [SAMPLE_W:0]     out_first,
    output logic [SAMPLE_W:0]     out_second,
    output logic                  orphan_flag,
    output logic [SAMPLE_W:0]     orphan_data
);
    localparam int DW = SAMPLE_W + 1;

    logic             pair_valid;
    logic [DW-1:0]    pair_a;
    logic [DW-1:0]    pair_b;
    lift_mode_e       pair_mode;
    logic             s2_valid;
    logic [DW-1:0]    s2_diff;
    logic [DW-1:0]    s2_pass;
    lift_mode_e       s2_mode;
    lift_mode_e       out_mode;

    haar_pair_capture #(.SAMPLE_W(SAMPLE_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_inv    (mode_inv),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .pair_valid  (pair_valid),
        .pair_a      (pair_a),
        .pair_b      (pair_b),
        .pair_mode   (pair_mode),
        .orphan_flag (orphan_flag),
        .orphan_data (orphan_data)
    );

    haar_sub_stage #(.SAMPLE_W(SAMPLE_W)) u_sub (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_valid (pair_valid),
        .pair_a     (pair_a),
        .pair_b     (pair_b),
        .pair_mode  (pair_mode),
        .s2_valid   (s2_valid),
        .s2_diff    (s2_diff),
        .s2_pass    (s2_pass),
        .s2_mode    (s2_mode)
    );

    haar_add_stage #(.SAMPLE_W(SAMPLE_W)) u_add (
        .clk        (clk),
        .rst_n      (rst_n),
        .s2_valid   (s2_valid),
        .s2_diff    (s2_diff),
        .s2_pass    (s2_pass),
        .s2_mode    (s2_mode),
        .out_valid  (out_valid),
        .out_first  (out_first),
        .out_second (out_second),
        .out_mode   (out_mode)
    );

    // R1: nothing is flagged on the cycle after a reset edge.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !orphan_flag && !in_ready));

    // R8: a held orphan stays unchanged while no beat is accepted.
    p_orphan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (orphan_flag && !(in_valid && in_ready)) |=> (orphan_flag && $stable(orphan_data)));

endmodule

// File: tb/sim_haar_lift_unit.sv
// Self-checking bench: exhaustive sweeps at SAMPLE_W = 4.
module sim_haar_lift_unit;
    localparam int W  = 4;
    localparam int DW = W + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_inv = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_first;
    logic [DW-1:0] out_second;
    logic          orphan_flag;
    logic [DW-1:0] orphan_data;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    haar_lift_unit #(.SAMPLE_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_inv(mode_inv), .in_valid(in_valid),
        .in_last(in_last), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_first(out_first), .out_second(out_second),
        .orphan_flag(orphan_flag), .orphan_data(orphan_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one pair; m1/m2 are the mode values at the first and second beat.
    task automatic send_pair(input logic m1, input logic m2,
                             input logic [DW-1:0] a, input logic [DW-1:0] b,
                             output logic [DW-1:0] f, output logic [DW-1:0] s);
        @(negedge clk);
        in_valid = 1'b1; mode_inv = m1; in_data = a; in_last = 1'b0;
        @(negedge clk);
        mode_inv = m2; in_data = b; in_last = 1'b1;
        @(negedge clk);               // second beat accepted at the edge just passed
        in_valid = 1'b0; in_last = 1'b0;
        @(posedge clk);
        #1 chk(out_valid == 1'b0, "R6 early", int'(out_valid), 0);
        @(posedge clk);
        #1 chk(out_valid == 1'b1, "R6", int'(out_valid), 1);
        f = out_first; s = out_second;
        @(posedge clk);
        #1 chk(out_valid == 1'b0, "R7", int'(out_valid), 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] f, s, f2, s2, ef, es;
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
        chk(orphan_flag == 0, "R1 orphan_flag", int'(orphan_flag), 0);
        chk(in_ready == 0, "R1 in_ready in reset", int'(in_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1 chk(in_ready == 1, "R1 in_ready after reset", int'(in_ready), 1);

        // R3 R5 R10: every forward pair, bit W driven with garbage, then round trip.
        for (int e = -8; e <= 7; e++) begin
            for (int o = -8; o <= 7; o++) begin
                int d, sa;
                logic [DW-1:0] av, bv;
                d  = o - e;
                sa = e + (d >>> 1);
                av = DW'(e); av[W] = ~av[W] ^ o[0];
                bv = DW'(o); bv[W] = bv[W] ^ e[0];
                send_pair(1'b0, 1'b0, av, bv, f, s);
                ef = DW'(sa); es = DW'(d);
                chk(f == ef, "R3 approx (R10)", int'(f), int'(ef));
                chk(s == es, "R3 detail (R10)", int'(s), int'(es));
                send_pair(1'b1, 1'b1, f, s, f2, s2);
                chk(f2 == DW'(e), "R5 even", int'(f2), e);
                chk(s2 == DW'(o), "R5 odd", int'(s2), o);
            end
        end

        // R4: every inverse input pair over all SAMPLE_W+1-bit codes.
        for (int sv = -16; sv <= 15; sv++) begin
            for (int dv = -16; dv <= 15; dv++) begin
                int ev, ov;
                ev = sv - (dv >>> 1);
                ov = dv + ev;
                send_pair(1'b1, 1'b1, DW'(sv), DW'(dv), f, s);
                ef = DW'(ev); es = DW'(ov);
                chk(f == ef, "R4 even", int'(f), int'(ef));
                chk(s == es, "R4 odd", int'(s), int'(es));
            end
        end

        // R9: mode at the second beat is ignored (forward then inverse latched).
        send_pair(1'b0, 1'b1, 5'd3, 5'd7, f, s);
        chk(f == 5'd5 && s == 5'd4, "R9 fwd latched", int'({f, s}), int'({5'd5, 5'd4}));
        send_pair(1'b1, 1'b0, 5'd5, 5'd4, f, s);
        chk(f == 5'd3 && s == 5'd7, "R9 inv latched", int'({f, s}), int'({5'd3, 5'd7}));

        // R2 R7: back-to-back beats give one pulse every two cycles.
        @(negedge clk);
        in_valid = 1; mode_inv = 0; in_last = 0; in_data = 5'd1;
        @(negedge clk); in_data = 5'd2;
        @(negedge clk); in_data = 5'd4;
        @(negedge clk); in_data = 5'd0;
        @(posedge clk);
        #1 chk(out_valid == 1 && out_second == 5'd1 && out_first == 5'd1,
               "R2 first of burst", int'({out_first, out_second}), int'({5'd1, 5'd1}));
        @(negedge clk); in_valid = 0;
        @(posedge clk);
        #1 chk(out_valid == 0, "R7 gap in burst", int'(out_valid), 0);
        @(posedge clk);
        #1 chk(out_valid == 1 && out_second == 5'h1C && out_first == 5'd2,
               "R2 second of burst", int'({out_first, out_second}), int'({5'd2, 5'h1C}));

        // R8: stream ending on a first-slot beat.
        @(negedge clk);
        in_valid = 1; mode_inv = 0; in_last = 1; in_data = 5'h1B;
        @(posedge clk);
        #1 chk(orphan_flag == 1, "R8 flag set", int'(orphan_flag), 1);
        chk(orphan_data == 5'h1B, "R8 data held", int'(orphan_data), 27);
        @(negedge clk); in_valid = 0; in_last = 0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1 chk(out_valid == 0 && orphan_flag == 1 && orphan_data == 5'h1B,
                   "R8 no pair, held", int'({out_valid, orphan_flag}), 1);
        end
        send_pair(1'b0, 1'b0, 5'd6, 5'd2, f, s);
        chk(f == 5'd4 && s == 5'h1C, "R8 new pair restarts", int'({f, s}), int'({5'd4, 5'h1C}));
        chk(orphan_flag == 0, "R8 flag cleared", int'(orphan_flag), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule